// File: doc/BRIEF.md
# Space Vector Triangle Locator

This block takes one sample of the three phase reference voltages of a three-level inverter and works out where that reference point sits in the hexagonal space-vector diagram. It converts the phase values to stationary alpha/beta coordinates. It then picks one of the six 60-degree sectors and rotates the point into the first sector. Last, it truncates two skewed coordinates to the integer pair k1/k2 and uses that pair to name one of the four small triangles inside the sector. Dwell-time calculation and switching-state ordering happen in a later stage, which uses the sector, the triangle and the pair.

All voltages are signed 16-bit values with 14 fraction bits. One level step of the inverter equals 1.0, which is 16384 counts. A sample is accepted on any rising edge with `in_valid` high. Its results appear together with `out_valid` after a fixed three-register pipeline. The outputs keep their last values between results.

Top module: `svtl_locator`

## Requirements
- R1: `alpha` equals floor((2·va − vb − vc)·5461 / 16384), where 5461/16384 stands for 1/3, saturated to the range −32768..32767.
- R2: `beta` equals floor((vb − vc)·9459 / 16384), where 9459/16384 stands for 1/√3, saturated to the range −32768..32767.
- R3: A common offset added to all three phases has no effect on any output.
- R4: Let t = floor(beta·9459/16384), p = alpha − t and e = alpha + t. When beta ≥ 0, `sector` is 1 if p ≥ 0, otherwise 2 if e ≥ 0, otherwise 3. When beta < 0, `sector` is 6 if e ≥ 0, otherwise 5 if p ≥ 0, otherwise 4. Sectors count counter-clockwise, and sector 1 starts at 0 degrees.
- R5: With q = floor(beta·18919/16384), where 18919/16384 stands for 2/√3, the point is rotated into sector 1 by taking (m, n) from the sector: 1: (p+q, q); 2: (q, −p); 3: (−p, −p−q); 4: (−p−q, −q); 5: (−q, p); 6: (p, p+q). `k1` is 1 when floor(m/16384) ≥ 1, otherwise 0. `k2` is 1 when floor(n/16384) ≥ 1, otherwise 0.
- R6: Without overmodulation, `triangle` is 1 when k1 = 0 and 4 when k1 = k2 = 1. When k1 = 1 and k2 = 0, it is 3 if (m mod 16384) + (n mod 16384) ≥ 16384, and 2 otherwise. A negative n counts as a zero fraction.
- R7: When floor(m/16384) ≥ 2, `overmod` is 1, `k1` is clamped to 1, and `triangle` is 4 if k2 = 1 and 3 otherwise. In every other case `overmod` is 0.
- R8: A sample taken with `in_valid` high on rising edge N sets `out_valid` high for one cycle after edge N+2, with its results. With no further samples, `out_valid` is low afterwards and the data outputs hold their values.
- R9: During and right after reset, `out_valid`, `alpha`, `beta`, `sector`, `k1`, `k2`, `triangle` and `overmod` are all zero.
- R10: Samples taken on consecutive edges produce results on consecutive cycles, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Phase sample present this cycle |
| va | input | 16 | Phase A reference, signed Q1.14 |
| vb | input | 16 | Phase B reference, signed Q1.14 |
| vc | input | 16 | Phase C reference, signed Q1.14 |
| out_valid | output | 1 | Result strobe |
| alpha | output | 16 | Stationary alpha coordinate, signed Q1.14 |
| beta | output | 16 | Stationary beta coordinate, signed Q1.14 |
| sector | output | 3 | Hexagon sector 1..6, 0 after reset |
| k1 | output | 1 | Clamped integer part of the first skewed coordinate |
| k2 | output | 1 | Clamped integer part of the second skewed coordinate |
| triangle | output | 3 | Triangle 1..4 within the sector, 0 after reset |
| overmod | output | 1 | Reference lies outside the hexagon |

## Verification
The bench places points inside each of the four sector-1 triangles. It then rotates a triangle-3 point and a triangle-2 point through all six sectors. A design with a wrong rotation or sign test would report the wrong sector, or a triangle that shifts as the point turns. A point whose fraction sum is above one tells apart triangles 2 and 3, which a design comparing only the integer pair would mix up. Further points cover overmodulation in two sectors, a saturating alpha, a common-mode offset, and two samples on back-to-back cycles. A design that skipped the clamp would report k1 = 2 truncated to 0. A design that failed to saturate would wrap the sign. A pipeline that reused stage registers would mix up the two back-to-back results.

// File: rtl/svtl_pkg.sv
package svtl_pkg;
    localparam int  DATA_W_DEF = 16;
    localparam int  FRAC_W_DEF = 14;
    localparam real SQRT3      = 1.7320508075688772;

    typedef logic [2:0] sector_t;
    typedef logic [2:0] tri_t;
endpackage

// File: rtl/svtl_clarke.sv
module svtl_clarke
    import svtl_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] va,
    input  logic signed [DATA_W-1:0] vb,
    input  logic signed [DATA_W-1:0] vc,
    output logic                     v_o,
    output logic signed [DATA_W-1:0] alpha_o,
    output logic signed [DATA_W-1:0] beta_o
);
    localparam int SW = DATA_W + 3;
    localparam int CW = FRAC_W + 2;
    localparam int PW = SW + CW;
    localparam logic signed [CW-1:0] K_THIRD = CW'((2**FRAC_W + 1) / 3);
    localparam logic signed [CW-1:0] K_ISQ3  = CW'(int'(real'(2**FRAC_W) / SQRT3));
    localparam logic signed [PW-1:0] MAXP    = PW'((2**(DATA_W-1)) - 1);
    localparam logic signed [PW-1:0] MINP    = -MAXP - PW'(1);

    typedef struct packed {
        logic                     v;
        logic signed [DATA_W-1:0] a;
        logic signed [DATA_W-1:0] b;
    } s1_t;

    s1_t s1_d, s1_q;
    logic signed [SW-1:0] diff_a, diff_b;
    logic signed [PW-1:0] a_full, b_full;

    function automatic logic signed [DATA_W-1:0] clip(input logic signed [PW-1:0] x);
        if (x > MAXP)      return MAXP[DATA_W-1:0];
        else if (x < MINP) return MINP[DATA_W-1:0];
        else               return x[DATA_W-1:0];
    endfunction

    always_comb begin
        diff_a = (SW'(va) <<< 1) - SW'(vb) - SW'(vc);
        diff_b = SW'(vb) - SW'(vc);
        a_full = (PW'(diff_a) * PW'(K_THIRD)) >>> FRAC_W;
        b_full = (PW'(diff_b) * PW'(K_ISQ3)) >>> FRAC_W;
        s1_d   = s1_q;
        s1_d.v = in_valid;
        if (in_valid) begin
            s1_d.a = clip(a_full);
            s1_d.b = clip(b_full);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end

    assign v_o     = s1_q.v;
    assign alpha_o = s1_q.a;
    assign beta_o  = s1_q.b;
endmodule

// File: rtl/svtl_sector.sv
module svtl_sector
    import svtl_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF,
    parameter int IW     = DATA_W + 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v_i,
    input  logic signed [DATA_W-1:0] alpha_i,
    input  logic signed [DATA_W-1:0] beta_i,
    output logic                     v_o,
    output sector_t                  sector_o,
    output logic signed [IW-1:0]     m_o,
    output logic signed [IW-1:0]     n_o,
    output logic signed [DATA_W-1:0] alpha_o,
    output logic signed [DATA_W-1:0] beta_o
);
    localparam int CW = FRAC_W + 2;
    localparam int PW = DATA_W + CW;
    localparam logic signed [CW-1:0] K_ISQ3  = CW'(int'(real'(2**FRAC_W) / SQRT3));
    localparam logic signed [CW-1:0] K_2ISQ3 = CW'(int'(real'(2**(FRAC_W+1)) / SQRT3));

    typedef struct packed {
        logic                     v;
        sector_t                  sec;
        logic signed [IW-1:0]     m;
        logic signed [IW-1:0]     n;
        logic signed [DATA_W-1:0] a;
        logic signed [DATA_W-1:0] b;
    } s2_t;

    s2_t s2_d, s2_q;
    logic signed [IW-1:0] t, q, p, e, m, n;
    sector_t sec;

    always_comb begin
        t = IW'((PW'(beta_i) * PW'(K_ISQ3)) >>> FRAC_W);
        q = IW'((PW'(beta_i) * PW'(K_2ISQ3)) >>> FRAC_W);
        p = IW'(alpha_i) - t;
        e = IW'(alpha_i) + t;
        if (!beta_i[DATA_W-1]) sec = !p[IW-1] ? 3'd1 : (!e[IW-1] ? 3'd2 : 3'd3);
        else                   sec = !e[IW-1] ? 3'd6 : (!p[IW-1] ? 3'd5 : 3'd4);
        case (sec)
            3'd1:    begin m = p + q;  n = q;      end
            3'd2:    begin m = q;      n = -p;     end
            3'd3:    begin m = -p;     n = -p - q; end
            3'd4:    begin m = -p - q; n = -q;     end
            3'd5:    begin m = -q;     n = p;      end
            default: begin m = p;      n = p + q;  end
        endcase
        s2_d   = s2_q;
        s2_d.v = v_i;
        if (v_i) begin
            s2_d.sec = sec;
            s2_d.m   = m;
            s2_d.n   = n;
            s2_d.a   = alpha_i;
            s2_d.b   = beta_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s2_q <= '0;
        else        s2_q <= s2_d;
    end

    assign v_o      = s2_q.v;
    assign sector_o = s2_q.sec;
    assign m_o      = s2_q.m;
    assign n_o      = s2_q.n;
    assign alpha_o  = s2_q.a;
    assign beta_o   = s2_q.b;

    // R4: a stage-2 result always carries a legal sector code
    a_r4_sector_code: assert property (@(posedge clk) disable iff (!rst_n)
        v_o |-> (sector_o >= 3'd1 && sector_o <= 3'd6));
endmodule

// File: rtl/svtl_tri.sv
module svtl_tri
    import svtl_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF,
    parameter int IW     = DATA_W + 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     v_i,
    input  sector_t                  sector_i,
    input  logic signed [IW-1:0]     m_i,
    input  logic signed [IW-1:0]     n_i,
    input  logic signed [DATA_W-1:0] alpha_i,
    input  logic signed [DATA_W-1:0] beta_i,
    output logic                     v_o,
    output sector_t                  sector_o,
    output logic                     k1_o,
    output logic                     k2_o,
    output tri_t                     tri_o,
    output logic                     ovm_o,
    output logic signed [DATA_W-1:0] alpha_o,
    output logic signed [DATA_W-1:0] beta_o
);
    localparam logic signed [IW-1:0] ONE = IW'(1);

    typedef struct packed {
        logic                     v;
        sector_t                  sec;
        logic                     k1;
        logic                     k2;
        tri_t                     tri_n;
        logic                     ovm;
        logic signed [DATA_W-1:0] a;
        logic signed [DATA_W-1:0] b;
    } s3_t;

    s3_t s3_d, s3_q;
    logic signed [IW-1:0] k1raw, k2raw;
    logic [FRAC_W-1:0] fm, fn;
    logic [FRAC_W:0]   fsum;
    logic over, k1, k2;
    tri_t tri_n;

    always_comb begin
        k1raw = m_i >>> FRAC_W;
        k2raw = n_i >>> FRAC_W;
        fm    = m_i[FRAC_W-1:0];
        fn    = n_i[IW-1] ? '0 : n_i[FRAC_W-1:0];
        fsum  = {1'b0, fm} + {1'b0, fn};
        over  = k1raw > ONE;
        k1    = k1raw >= ONE;
        k2    = k2raw >= ONE;
        if (over)          tri_n = k2 ? 3'd4 : 3'd3;
        else if (!k1)      tri_n = 3'd1;
        else if (k2)       tri_n = 3'd4;
        else if (fsum[FRAC_W]) tri_n = 3'd3;
        else               tri_n = 3'd2;
        s3_d   = s3_q;
        s3_d.v = v_i;
        if (v_i) begin
            s3_d.sec   = sector_i;
            s3_d.k1    = k1;
            s3_d.k2    = k2;
            s3_d.tri_n = tri_n;
            s3_d.ovm   = over;
            s3_d.a     = alpha_i;
            s3_d.b     = beta_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s3_q <= '0;
        else        s3_q <= s3_d;
    end

    assign v_o      = s3_q.v;
    assign sector_o = s3_q.sec;
    assign k1_o     = s3_q.k1;
    assign k2_o     = s3_q.k2;
    assign tri_o    = s3_q.tri_n;
    assign ovm_o    = s3_q.ovm;
    assign alpha_o  = s3_q.a;
    assign beta_o   = s3_q.b;
endmodule

// File: rtl/svtl_locator.sv
module svtl_locator
    import svtl_pkg::*;
#(
    parameter int DATA_W = DATA_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] va,
    input  logic signed [DATA_W-1:0] vb,
    input  logic signed [DATA_W-1:0] vc,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] alpha,
    output logic signed [DATA_W-1:0] beta,
    output logic [2:0]               sector,
    output logic                     k1,
    output logic                     k2,
    output logic [2:0]               triangle,
    output logic                     overmod
);
    localparam int IW = DATA_W + 4;

    logic                     v1, v2;
    logic signed [DATA_W-1:0] a1, b1, a2, b2;
    sector_t                  sec2;
    logic signed [IW-1:0]     m2, n2;

    svtl_clarke #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_clarke (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .va(va), .vb(vb), .vc(vc),
        .v_o(v1), .alpha_o(a1), .beta_o(b1)
    );

    svtl_sector #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .IW(IW)) u_sector (
        .clk(clk), .rst_n(rst_n), .v_i(v1), .alpha_i(a1), .beta_i(b1),
        .v_o(v2), .sector_o(sec2), .m_o(m2), .n_o(n2),
        .alpha_o(a2), .beta_o(b2)
    );

    svtl_tri #(.DATA_W(DATA_W), .FRAC_W(FRAC_W), .IW(IW)) u_tri (
        .clk(clk), .rst_n(rst_n), .v_i(v2), .sector_i(sec2),
        .m_i(m2), .n_i(n2), .alpha_i(a2), .beta_i(b2),
        .v_o(out_valid), .sector_o(sector), .k1_o(k1), .k2_o(k2),
        .tri_o(triangle), .ovm_o(overmod), .alpha_o(alpha), .beta_o(beta)
    );

    // R8: every accepted sample yields a strobe three edges later
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##3 out_valid);

    // R8: no strobe without a sample three edges earlier
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##3 !out_valid);

    // R7: an overmodulated result is clamped to an outer triangle
    a_r7_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        overmod |-> (k1 && (triangle == 3'd3 || triangle == 3'd4)));
endmodule

// File: tb/sim_svtl_locator.sv
`timescale 1ns/1ps
module sim_svtl_locator;
    localparam int CLK_PERIOD = 10;
    localparam real HS3 = 0.8660254037844386;

    typedef struct {
        int a; int b; int s; int k1; int k2; int t; int o;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] va = '0, vb = '0, vc = '0;
    logic out_valid, k1, k2, overmod;
    logic signed [15:0] alpha, beta;
    logic [2:0] sector, triangle;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    svtl_locator u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .va(va), .vb(vb), .vc(vc),
        .out_valid(out_valid), .alpha(alpha), .beta(beta),
        .sector(sector), .k1(k1), .k2(k2), .triangle(triangle), .overmod(overmod)
    );

    task automatic check(string req, string what, int act, int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint sat16(longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic int q14(real x);
        return int'(sat16(longint'(x * 16384.0)));
    endfunction

    // expected results from R1, R2, R4..R7
    function automatic exp_t model(int pa, int pb, int pc);
        exp_t r;
        longint a, b, t, q, p, e, m, n, k1r, k2r, fm, fn;
        a = sat16(((2*longint'(pa) - pb - pc) * 5461) >>> 14);
        b = sat16(((longint'(pb) - pc) * 9459) >>> 14);
        t = (b * 9459) >>> 14;
        q = (b * 18919) >>> 14;
        p = a - t;
        e = a + t;
        if (b >= 0) r.s = (p >= 0) ? 1 : ((e >= 0) ? 2 : 3);
        else        r.s = (e >= 0) ? 6 : ((p >= 0) ? 5 : 4);
        case (r.s)
            1: begin m = p + q;  n = q;      end
            2: begin m = q;      n = -p;     end
            3: begin m = -p;     n = -p - q; end
            4: begin m = -p - q; n = -q;     end
            5: begin m = -q;     n = p;      end
            default: begin m = p; n = p + q; end
        endcase
        k1r = m >>> 14;
        k2r = n >>> 14;
        fm = m & 16383;
        fn = (n < 0) ? 0 : (n & 16383);
        r.a = int'(a);
        r.b = int'(b);
        r.k1 = (k1r >= 1) ? 1 : 0;
        r.k2 = (k2r >= 1) ? 1 : 0;
        r.o = (k1r >= 2) ? 1 : 0;
        if (r.o == 1)       r.t = (r.k2 == 1) ? 4 : 3;
        else if (r.k1 == 0) r.t = 1;
        else if (r.k2 == 1) r.t = 4;
        else                r.t = (fm + fn >= 16384) ? 3 : 2;
        return r;
    endfunction

    task automatic set_phases(real a, real b, real cm);
        va = 16'(q14(a + cm));
        vb = 16'(q14(-0.5*a + HS3*b + cm));
        vc = 16'(q14(-0.5*a - HS3*b + cm));
    endtask

    task automatic check_out(string req, exp_t x, int esec, int etri);
        check("R8", "out_valid", int'(out_valid), 1);
        check("R1", "alpha", int'(alpha), x.a);
        check("R2", "beta", int'(beta), x.b);
        check("R4", "sector", int'(sector), x.s);
        if (esec > 0) check(req, "sector explicit", int'(sector), esec);
        check("R5", "k1", int'(k1), x.k1);
        check("R5", "k2", int'(k2), x.k2);
        check("R6", "triangle", int'(triangle), x.t);
        if (etri > 0) check(req, "triangle explicit", int'(triangle), etri);
        check("R7", "overmod", int'(overmod), x.o);
    endtask

    // one sample, latency and hold checked around it (R8)
    task automatic run_point(string req, real a, real b, real cm, int esec, int etri);
        exp_t x;
        logic signed [15:0] held;
        @(negedge clk);
        set_phases(a, b, cm);
        x = model(int'(va), int'(vb), int'(vc));
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R8", "early out_valid", int'(out_valid), 0);
        @(negedge clk);
        check_out(req, x, esec, etri);
        held = alpha;
        @(negedge clk);
        check("R8", "strobe width", int'(out_valid), 0);
        check("R8", "alpha hold", int'(alpha), int'(held));
        check("R8", "triangle hold", int'(triangle), x.t);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R9", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "out_valid", int'(out_valid), 0);
        check("R9", "alpha", int'(alpha), 0);
        check("R9", "beta", int'(beta), 0);
        check("R9", "sector", int'(sector), 0);
        check("R9", "k1", int'(k1), 0);
        check("R9", "k2", int'(k2), 0);
        check("R9", "triangle", int'(triangle), 0);
        check("R9", "overmod", int'(overmod), 0);
    endtask

    task automatic t_sector1_triangles();
        run_point("R6", 0.5, 0.2, 0.0, 1, 1);
        run_point("R6", 1.2, 0.2, 0.0, 1, 2);
        run_point("R6", 1.6, 0.6, 0.0, 1, 3);
        run_point("R6", 1.0, 1.0, 0.0, 1, 4);
    endtask

    task automatic t_all_sectors();
        real x3 = 1.6, y3 = 0.6, x2 = 1.2, y2 = 0.2, nx;
        for (int k = 0; k < 6; k++) begin
            run_point("R4", x3, y3, 0.0, k + 1, 3);
            run_point("R5", x2, y2, 0.0, k + 1, 2);
            nx = 0.5*x3 - HS3*y3; y3 = HS3*x3 + 0.5*y3; x3 = nx;
            nx = 0.5*x2 - HS3*y2; y2 = HS3*x2 + 0.5*y2; x2 = nx;
        end
    endtask

    task automatic t_common_mode();
        // R3: offset must leave every output as without it
        run_point("R3", 0.5, 0.2, 0.3, 1, 1);
        run_point("R3", 1.6, 0.6, -0.25, 1, 3);
    endtask

    task automatic t_overmod();
        run_point("R7", 1.9, 0.5, 0.0, 1, 3);
        check("R7", "overmod flag", int'(overmod), 1);
        check("R7", "k1 clamp", int'(k1), 1);
        run_point("R7", -1.9, -0.5, 0.0, 4, 3);
        check("R7", "overmod flag s4", int'(overmod), 1);
    endtask

    task automatic t_saturate();
        exp_t x;
        @(negedge clk);
        va = 16'sd32600; vb = -16'sd32600; vc = -16'sd32600;
        x = model(int'(va), int'(vb), int'(vc));
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check_out("R1", x, 1, 0);
        check("R1", "alpha saturated", int'(alpha), 32767);
    endtask

    task automatic t_back_to_back();
        exp_t x1, x2;
        @(negedge clk);
        set_phases(0.5, 0.2, 0.0);
        x1 = model(int'(va), int'(vb), int'(vc));
        in_valid = 1'b1;
        @(negedge clk);
        set_phases(-1.0, -1.0, 0.0);
        x2 = model(int'(va), int'(vb), int'(vc));
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check_out("R10", x1, 1, 1);
        @(negedge clk);
        check_out("R10", x2, 4, 4);
        @(negedge clk);
        check("R10", "out_valid after pair", int'(out_valid), 0);
    endtask

    initial begin
        t_reset();
        t_sector1_triangles();
        t_all_sectors();
        t_common_mode();
        t_overmod();
        t_saturate();
        t_back_to_back();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end
endmodule